// File: doc/BRIEF.md
# Privilege-Aware Interrupt Prioritizer

This block holds the pending interrupts of one processor thread and decides which of them the thread should take. Seven source types each own a 64-bit pending vector and a one-bit summary flag. Requesters set or clear single bits through a post port and a clear port, and a clear-all strobe empties everything.

From the summary flags and the thread's current hyperprivileged and interrupt-enable bits, the block computes three things in the same cycle: whether an interrupt is due, which source type wins, and the priority level implied by the soft-interrupt vector. A read port returns any type's vector combinationally. Taking an interrupt leaves every pending bit in place. Only the clear port or clear-all removes state.

Source type indices are 0 trap-level-zero, 1 tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 soft interrupt and 6 resumable error. The winner code is the type index plus one, and 0 means no interrupt.

Top module: `irq_prioritizer`

## Requirements
- R1: A post with type below 7 sets bit `post_bit` of that type's vector and sets that type's summary flag (`type_busy[type]`) on the next clock edge.
- R2: A clear sets bit `clr_bit` of that type's vector to zero. The summary flag drops only when the whole vector of that type has become zero.
- R3: If a post and a clear address the same bit of the same type in one cycle, the bit is set after the edge.
- R4: A post or clear whose type field is 7 changes no vector and no summary flag.
- R5: `clr_all` (and `rst`) zeroes every vector and every summary flag, and it wins over a post in the same cycle.
- R6: With every summary flag at zero, `irq_pending` is 0 and `irq_code` is 0 in every mode.
- R7: With `hpriv`=1 and `int_en`=0 nothing is signalled. With `hpriv`=1 and `int_en`=1, tick match (code 2) wins over interrupt vector (code 3), and all other types are masked.
- R8: With `hpriv`=0, the order is trap-level-zero (code 1), tick match (code 2), then interrupt vector (code 3). These three are taken regardless of `int_en`.
- R9: With `hpriv`=0 and `int_en`=1, the next candidates in order are CPU mondo (4), device mondo (5), soft interrupt (6) and resumable error (7). With `int_en`=0 these four are masked.
- R10: `soft_level` is 14 when soft bit 16 or bit 0 is set. Otherwise it is the index of the highest set bit among bits 15..1, or 0 when none of those is set.
- R11: `irq_pending` equals (`irq_code` != 0), and a signalled interrupt stays pending over later cycles until it is cleared.
- R12: `rd_vec` shows the current vector of type `rd_type` in the same cycle, and shows zero for type 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request valid |
| post_type | input | 3 | Source type to post to |
| post_bit | input | 6 | Bit index to set |
| clr_vld | input | 1 | Clear request valid |
| clr_type | input | 3 | Source type to clear in |
| clr_bit | input | 6 | Bit index to clear |
| clr_all | input | 1 | Empty all vectors and flags |
| hpriv | input | 1 | Thread is hyperprivileged |
| int_en | input | 1 | Thread interrupt enable |
| rd_type | input | 3 | Type selected for the read port |
| rd_vec | output | 64 | Pending vector of `rd_type` |
| type_busy | output | 7 | Per-type summary flags |
| irq_pending | output | 1 | An interrupt is due |
| irq_code | output | 3 | Winning type plus one, 0 for none |
| soft_level | output | 4 | Level derived from the soft vector |

## Verification
Within one clock edge, a bit update can meet a second request in two ways. A post can arrive together with a clear, and a post can arrive together with the clear-all strobe. The bench drives both pairs in the same cycle. It first aims a post and a clear at the same bit, then at different bits of one type, and expects the set bit to survive and the summary flag to follow the resulting vector. It then raises clear-all beside a post and expects every vector and flag to read back as zero afterwards.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
    localparam int unsigned NUM_SRC = 7;
    localparam int unsigned TYPE_W  = 3;
    localparam int unsigned LVL_W   = 4;

    typedef enum logic [TYPE_W-1:0] {
        SRC_TLZ  = 3'd0,
        SRC_TICK = 3'd1,
        SRC_IVEC = 3'd2,
        SRC_CPUQ = 3'd3,
        SRC_DEVQ = 3'd4,
        SRC_SOFT = 3'd5,
        SRC_RERR = 3'd6
    } src_e;

    typedef enum logic [TYPE_W-1:0] {
        WIN_NONE = 3'd0,
        WIN_TLZ  = 3'd1,
        WIN_TICK = 3'd2,
        WIN_IVEC = 3'd3,
        WIN_CPUQ = 3'd4,
        WIN_DEVQ = 3'd5,
        WIN_SOFT = 3'd6,
        WIN_RERR = 3'd7
    } win_e;

    function automatic win_e src_to_win(input src_e s);
        return win_e'(s + 3'd1);
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 64,
    localparam int unsigned IDX_W = $clog2(VEC_W)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             post_vld,
    input  logic [TYPE_W-1:0]                post_type,
    input  logic [IDX_W-1:0]                 post_bit,
    input  logic                             clr_vld,
    input  logic [TYPE_W-1:0]                clr_type,
    input  logic [IDX_W-1:0]                 clr_bit,
    input  logic                             clr_all,
    output logic [NUM_SRC-1:0][VEC_W-1:0]    vec_q,
    output logic [NUM_SRC-1:0]               busy_q
);
    localparam logic [VEC_W-1:0] ONE = {{(VEC_W-1){1'b0}}, 1'b1};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic             post_hit;
        logic             clr_hit;
        logic [VEC_W-1:0] set_m;
        logic [VEC_W-1:0] clr_m;
        logic [VEC_W-1:0] nxt;

        always_comb begin
            post_hit = post_vld && (post_type == TYPE_W'(g));
            clr_hit  = clr_vld && (clr_type == TYPE_W'(g));
            set_m    = post_hit ? (ONE << post_bit) : '0;
            clr_m    = clr_hit ? (ONE << clr_bit) : '0;
            // set mask applied after clear mask: post wins on a shared bit
            nxt      = (vec_q[g] & ~clr_m) | set_m;
        end

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                vec_q[g]  <= '0;
                busy_q[g] <= 1'b0;
            end else begin
                vec_q[g]  <= nxt;
                busy_q[g] <= post_hit || (busy_q[g] && (|nxt));
            end
        end
    end
endmodule

// File: rtl/irq_soft_level.sv
`timescale 1ns/1ps
module irq_soft_level
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 64
) (
    input  logic [VEC_W-1:0] soft_vec,
    output logic [LVL_W-1:0] level
);
    localparam int unsigned TOP_SCAN = 15;
    localparam int unsigned FORCE_HI = 16;
    localparam logic [LVL_W-1:0] FORCED_LVL = LVL_W'(14);

    always_comb begin
        level = '0;
        for (int i = 1; i <= TOP_SCAN; i++) begin
            if (soft_vec[i]) level = LVL_W'(i);
        end
        if (soft_vec[FORCE_HI] || soft_vec[0]) level = FORCED_LVL;
    end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] busy,
    input  logic               hpriv,
    input  logic               int_en,
    output logic               pending,
    output win_e               code
);
    always_comb begin
        code = WIN_NONE;
        if (hpriv) begin
            if (int_en) begin
                if (busy[SRC_TICK])      code = src_to_win(SRC_TICK);
                else if (busy[SRC_IVEC]) code = src_to_win(SRC_IVEC);
            end
        end else begin
            if (busy[SRC_TLZ])           code = src_to_win(SRC_TLZ);
            else if (busy[SRC_TICK])     code = src_to_win(SRC_TICK);
            else if (busy[SRC_IVEC])     code = src_to_win(SRC_IVEC);
            else if (int_en) begin
                if (busy[SRC_CPUQ])      code = src_to_win(SRC_CPUQ);
                else if (busy[SRC_DEVQ]) code = src_to_win(SRC_DEVQ);
                else if (busy[SRC_SOFT]) code = src_to_win(SRC_SOFT);
                else if (busy[SRC_RERR]) code = src_to_win(SRC_RERR);
            end
        end
        pending = (code != WIN_NONE);
    end
endmodule

// File: rtl/irq_prioritizer.sv
`timescale 1ns/1ps
module irq_prioritizer
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 64,
    localparam int unsigned IDX_W = $clog2(VEC_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                post_vld,
    input  logic [TYPE_W-1:0]   post_type,
    input  logic [IDX_W-1:0]    post_bit,
    input  logic                clr_vld,
    input  logic [TYPE_W-1:0]   clr_type,
    input  logic [IDX_W-1:0]    clr_bit,
    input  logic                clr_all,
    input  logic                hpriv,
    input  logic                int_en,
    input  logic [TYPE_W-1:0]   rd_type,
    output logic [VEC_W-1:0]    rd_vec,
    output logic [NUM_SRC-1:0]  type_busy,
    output logic                irq_pending,
    output logic [TYPE_W-1:0]   irq_code,
    output logic [LVL_W-1:0]    soft_level
);
    logic [NUM_SRC-1:0][VEC_W-1:0] vec_q;
    win_e                          win;

    irq_pend_bank #(.VEC_W(VEC_W)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .post_vld  (post_vld),
        .post_type (post_type),
        .post_bit  (post_bit),
        .clr_vld   (clr_vld),
        .clr_type  (clr_type),
        .clr_bit   (clr_bit),
        .clr_all   (clr_all),
        .vec_q     (vec_q),
        .busy_q    (type_busy)
    );

    irq_soft_level #(.VEC_W(VEC_W)) lvl_i (
        .soft_vec (vec_q[SRC_SOFT]),
        .level    (soft_level)
    );

    irq_arbiter arb_i (
        .busy    (type_busy),
        .hpriv   (hpriv),
        .int_en  (int_en),
        .pending (irq_pending),
        .code    (win)
    );

    assign irq_code = win;

    always_comb begin
        rd_vec = '0;
        for (int t = 0; t < NUM_SRC; t++) begin
            if (rd_type == TYPE_W'(t)) rd_vec = vec_q[t];
        end
    end
endmodule

// File: rtl/irq_prioritizer_chk.sv
`timescale 1ns/1ps
module irq_prioritizer_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 64,
    localparam int unsigned IDX_W = $clog2(VEC_W)
) (
    input logic                clk,
    input logic                rst,
    input logic                post_vld,
    input logic [TYPE_W-1:0]   post_type,
    input logic [IDX_W-1:0]    post_bit,
    input logic                clr_vld,
    input logic [TYPE_W-1:0]   clr_type,
    input logic [IDX_W-1:0]    clr_bit,
    input logic                clr_all,
    input logic                hpriv,
    input logic                int_en,
    input logic [TYPE_W-1:0]   rd_type,
    input logic [VEC_W-1:0]    rd_vec,
    input logic [NUM_SRC-1:0]  type_busy,
    input logic                irq_pending,
    input logic [TYPE_W-1:0]   irq_code,
    input logic [LVL_W-1:0]    soft_level
);
    // R1
    post_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (post_vld && post_type < TYPE_W'(NUM_SRC) && !clr_all) |=> type_busy[$past(post_type)]);

    // R5
    clear_all_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (type_busy == '0 && rd_vec == '0));

    // R6
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (type_busy == '0) |-> (!irq_pending && irq_code == '0));

    // R7
    hpriv_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (hpriv && !int_en) |-> !irq_pending);

    // R7
    hpriv_codes_chk: assert property (@(posedge clk) disable iff (rst)
        hpriv |-> (irq_code == 3'd0 || irq_code == 3'd2 || irq_code == 3'd3));

    // R11
    flag_code_agree_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pending == (irq_code != '0));
endmodule

bind irq_prioritizer irq_prioritizer_chk #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/irq_prioritizer_tb_top.sv
`timescale 1ns/1ps
module irq_prioritizer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_vld = 1'b0;
    logic [2:0]  post_type = '0;
    logic [5:0]  post_bit = '0;
    logic        clr_vld = 1'b0;
    logic [2:0]  clr_type = '0;
    logic [5:0]  clr_bit = '0;
    logic        clr_all = 1'b0;
    logic        hpriv = 1'b0;
    logic        int_en = 1'b0;
    logic [2:0]  rd_type = '0;
    logic [63:0] rd_vec;
    logic [6:0]  type_busy;
    logic        irq_pending;
    logic [2:0]  irq_code;
    logic [3:0]  soft_level;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_prioritizer dut_i (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_vec(input logic [2:0] t, output logic [63:0] v);
        rd_type = t;
        #1;
        v = rd_vec;
    endtask

    task automatic post(input logic [2:0] t, input logic [5:0] b);
        @(negedge clk);
        post_vld = 1'b1; post_type = t; post_bit = b;
        @(negedge clk);
        post_vld = 1'b0;
    endtask

    task automatic clear(input logic [2:0] t, input logic [5:0] b);
        @(negedge clk);
        clr_vld = 1'b1; clr_type = t; clr_bit = b;
        @(negedge clk);
        clr_vld = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    task automatic post_all();
        for (int t = 0; t < 7; t++) post(3'(t), 6'd1);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R5 reset busy", 64'(type_busy), 64'd0);
        check("R6 reset pending", 64'(irq_pending), 64'd0);
        check("R6 reset code", 64'(irq_code), 64'd0);
        read_vec(3'd2, v);
        check("R5 reset vec", v, 64'd0);
    endtask

    task automatic t_post_clear();
        logic [63:0] v;
        wipe();
        post(3'd2, 6'd5);
        read_vec(3'd2, v);
        check("R1 post vec", v, 64'h20);
        check("R1 post busy", 64'(type_busy), 64'h04);
        post(3'd2, 6'd63);
        clear(3'd2, 6'd5);
        read_vec(3'd2, v);
        check("R2 partial clear vec", v, 64'h8000_0000_0000_0000);
        check("R2 partial clear busy", 64'(type_busy), 64'h04);
        clear(3'd2, 6'd63);
        check("R2 empty clear busy", 64'(type_busy), 64'h00);
        read_vec(3'd7, v);
        check("R12 type7 read", v, 64'd0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] v;
        wipe();
        @(negedge clk);
        post_vld = 1'b1; post_type = 3'd4; post_bit = 6'd9;
        clr_vld = 1'b1;  clr_type = 3'd4;  clr_bit = 6'd9;
        @(negedge clk);
        post_vld = 1'b0; clr_vld = 1'b0;
        read_vec(3'd4, v);
        check("R3 post beats clear", v, 64'h200);
        @(negedge clk);
        post_vld = 1'b1; post_type = 3'd4; post_bit = 6'd2;
        clr_vld = 1'b1;  clr_type = 3'd4;  clr_bit = 6'd9;
        @(negedge clk);
        post_vld = 1'b0; clr_vld = 1'b0;
        read_vec(3'd4, v);
        check("R3 distinct bits", v, 64'h4);
        check("R2 busy kept", 64'(type_busy), 64'h10);
        @(negedge clk);
        post_vld = 1'b1; post_type = 3'd1; post_bit = 6'd0; clr_all = 1'b1;
        @(negedge clk);
        post_vld = 1'b0; clr_all = 1'b0;
        check("R5 clear-all beats post", 64'(type_busy), 64'd0);
        read_vec(3'd1, v);
        check("R5 clear-all vec", v, 64'd0);
    endtask

    task automatic t_bad_type();
        logic [63:0] v;
        wipe();
        post(3'd7, 6'd3);
        check("R4 bad post busy", 64'(type_busy), 64'd0);
        for (int t = 0; t < 7; t++) begin
            read_vec(3'(t), v);
            check("R4 bad post vec", v, 64'd0);
        end
        post(3'd0, 6'd3);
        clear(3'd7, 6'd3);
        read_vec(3'd0, v);
        check("R4 bad clear vec", v, 64'h8);
        check("R4 bad clear busy", 64'(type_busy), 64'h01);
    endtask

    task automatic t_hpriv();
        wipe();
        post_all();
        hpriv = 1'b1; int_en = 1'b0; #1;
        check("R7 hpriv ie0 pending", 64'(irq_pending), 64'd0);
        int_en = 1'b1; #1;
        check("R7 hpriv tick first", 64'(irq_code), 64'd2);
        clear(3'd1, 6'd1);
        check("R7 hpriv ivec next", 64'(irq_code), 64'd3);
        clear(3'd2, 6'd1);
        check("R7 hpriv others masked", 64'(irq_code), 64'd0);
        check("R7 hpriv pending low", 64'(irq_pending), 64'd0);
        hpriv = 1'b0;
    endtask

    task automatic t_normal();
        wipe();
        post_all();
        hpriv = 1'b0; int_en = 1'b0; #1;
        check("R8 tlz ignores ie", 64'(irq_code), 64'd1);
        int_en = 1'b1; #1;
        check("R8 tlz first", 64'(irq_code), 64'd1);
        clear(3'd0, 6'd1);
        check("R8 tick second", 64'(irq_code), 64'd2);
        clear(3'd1, 6'd1);
        int_en = 1'b0; #1;
        check("R8 ivec ignores ie", 64'(irq_code), 64'd3);
        clear(3'd2, 6'd1);
        check("R9 lower masked ie0", 64'(irq_pending), 64'd0);
        int_en = 1'b1; #1;
        check("R9 cpu mondo", 64'(irq_code), 64'd4);
        repeat (5) @(negedge clk);
        check("R11 no auto clear", 64'(irq_code), 64'd4);
        check("R11 pending flag", 64'(irq_pending), 64'd1);
        clear(3'd3, 6'd1);
        check("R9 dev mondo", 64'(irq_code), 64'd5);
        clear(3'd4, 6'd1);
        check("R9 soft", 64'(irq_code), 64'd6);
        clear(3'd5, 6'd1);
        check("R9 resumable error", 64'(irq_code), 64'd7);
        clear(3'd6, 6'd1);
        check("R6 all empty", 64'(irq_pending), 64'd0);
    endtask

    task automatic t_soft();
        wipe();
        post(3'd5, 6'd16);
        check("R10 bit16 level", 64'(soft_level), 64'd14);
        wipe();
        post(3'd5, 6'd0);
        post(3'd5, 6'd15);
        check("R10 bit0 overrides", 64'(soft_level), 64'd14);
        wipe();
        post(3'd5, 6'd3);
        post(3'd5, 6'd12);
        check("R10 highest bit", 64'(soft_level), 64'd12);
        wipe();
        post(3'd5, 6'd15);
        check("R10 bit15", 64'(soft_level), 64'd15);
        wipe();
        post(3'd5, 6'd20);
        hpriv = 1'b0; int_en = 1'b1; #1;
        check("R10 high-only level", 64'(soft_level), 64'd0);
        check("R10 high-only wins", 64'(irq_code), 64'd6);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_post_clear();
        t_same_cycle();
        t_bad_type();
        t_hpriv();
        t_normal();
        t_soft();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule